// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block derives the three clocks of an audio serial port that runs as clock master: an optional master clock, the bit clock and the word-select (frame) clock. All three come from one kernel clock. A single prescaler divides the kernel clock by an integer ratio built from an 8-bit divider field and an odd bit. Its output either leaves the block as the master clock, or it is used directly as the bit clock. When the master clock is enabled, the bit clock is a fixed fraction of it, so that a frame always spans 256 master-clock periods. The DSP/PCM framing is the exception: there a frame spans 128 master-clock periods.

The word-select clock counts bit-clock periods over a frame of two channels. Each channel is 16 or 32 bits long. The waveform of the word-select clock depends on the framing standard. The configuration is captured only while the enable input is low, so a running stream cannot be disturbed by a change to the settings. A divider setting that cannot be realised raises an error flag and keeps every clock quiet.

Top module: `acg_top`

## Requirements
- R1: With DIV>=1 (and not DIV=1 with ODD=1), the prescaler output has a period of exactly 2*DIV+ODD kernel-clock cycles.
- R2: Within each prescaler period the output is low for the first DIV cycles and high for the remaining DIV+ODD cycles. An even ratio therefore gives exactly 50% duty, and an odd ratio gives a duty within one kernel cycle of 50%.
- R3: DIV=0 selects bypass at ratio 1, whatever ODD is. The prescaler output is then the inverted kernel clock: low while the kernel clock is high and high while it is low.
- R4: DIV=1 together with ODD=1 sets cfg_err high one cycle after the setting is captured. While the flag is set, mclk stays low and sck and ws stay at their inactive levels, even with enable high.
- R5: With mclk_out_en=1, mclk is the prescaler output and one sck period lasts N mclk periods. N = 256/(2*CH) for frame_std 0, 1 and 2, and N = 128/(2*CH) for frame_std 3. So N is 8, 4, 4 or 2. sck is low for the first N/2 mclk periods and high for the rest.
- R6: With mclk_out_en=0, mclk is held low and sck is the prescaler output.
- R7: A frame lasts 2*CH sck periods, with CH=16 when chan_wide=0 and CH=32 when chan_wide=1. ws changes only at the start of an sck period, which is where sck falls.
- R8: Let b be the bit index within the frame, counted from 0. The non-inverted ws depends on frame_std. For frame_std=0 (I2S) ws is high when b>=CH. For frame_std=1 (MSB-aligned) and frame_std=2 (LSB-aligned) ws is high when b<CH. For frame_std=3 (short-sync PCM) ws is high only when b=0.
- R9: sck_invert=1 inverts sck and ws_invert=1 inverts ws. This applies while running and also to the inactive levels.
- R10: While the clocks are stopped, mclk=0, sck=sck_invert and ws=ws_invert. The clocks stop one cycle after enable is sampled low, and they are also stopped in reset.
- R11: Configuration inputs that change while enable is high have no effect until enable has been low for at least one clock edge.
- R12: On the first edge with enable high and a legal setting, the generator starts. In the next cycle it is at bit 0 of a frame, in the low phase of the first prescaler period and of the first sck period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Kernel clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the clocks while high; settings are captured while low |
| div_ratio | input | DIV_W (8) | Prescaler divider field DIV |
| div_odd | input | 1 | Adds one to the prescaler ratio |
| mclk_out_en | input | 1 | Drives the master clock and derives sck from it |
| chan_wide | input | 1 | Channel length: 0 selects 16 bits, 1 selects 32 bits |
| frame_std | input | 2 | Framing standard: 0 I2S, 1 MSB-aligned, 2 LSB-aligned, 3 short-sync PCM |
| sck_invert | input | 1 | Inverts the bit clock |
| ws_invert | input | 1 | Inverts the word-select clock |
| mclk | output | 1 | Master clock |
| sck | output | 1 | Bit clock |
| ws | output | 1 | Word-select clock |
| cfg_err | output | 1 | Illegal divider setting captured |

## Verification
The bench compares every kernel cycle of each run against a waveform model written from the requirements. It covers even and odd ratios, the largest ratio and both bypass forms (ODD clear and set). A duty or period error from an off-by-one in the low-phase count would show up as a misplaced mclk or sck edge. An mclk-per-bit ratio that does not follow the standard would give a wrong sck period in the DSP/PCM runs with both channel lengths. A word-select that ignores the standard or the channel length would flip at the wrong bit. Other targeted runs check three more points. The illegal 3-ratio setting must keep all clocks quiet. Settings changed mid-stream must not leak into the running clocks. The inactive levels must follow both inversion controls.

// File: rtl/acg_pkg.sv
`timescale 1ns/1ps
package acg_pkg;

    localparam int MCLK_FS_STD   = 256;
    localparam int MCLK_FS_PCM   = 128;
    localparam int CH_SHORT_BITS = 16;
    localparam int CH_LONG_BITS  = 32;

    typedef enum logic [1:0] {
        FMT_I2S       = 2'd0,
        FMT_MSB_ALIGN = 2'd1,
        FMT_LSB_ALIGN = 2'd2,
        FMT_PCM_SHORT = 2'd3
    } frame_std_e;

    typedef struct packed {
        logic       odd;
        logic       mclk_en;
        logic       chan_wide;
        frame_std_e std;
        logic       sck_inv;
        logic       ws_inv;
    } acg_mode_t;

    function automatic int unsigned chan_bits(input logic wide);
        return wide ? CH_LONG_BITS : CH_SHORT_BITS;
    endfunction

    // master-clock periods per bit-clock period
    function automatic int unsigned mclk_per_bit(input frame_std_e s, input logic wide);
        int unsigned fs;
        fs = (s == FMT_PCM_SHORT) ? MCLK_FS_PCM : MCLK_FS_STD;
        return fs / (2 * chan_bits(wide));
    endfunction

    // word-select level (before inversion) for bit b of a frame
    function automatic logic ws_for_bit(input frame_std_e s, input int unsigned b,
                                        input int unsigned ch);
        logic r;
        case (s)
            FMT_I2S:       r = (b >= ch);
            FMT_MSB_ALIGN,
            FMT_LSB_ALIGN: r = (b < ch);
            default:       r = (b == 0);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/acg_cfg_hold.sv
`timescale 1ns/1ps
module acg_cfg_hold
    import acg_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [DIV_W-1:0] div_i,
    input  acg_mode_t        mode_i,
    output logic [DIV_W-1:0] div_o,
    output acg_mode_t        mode_o,
    output logic             legal_o
);

    logic [DIV_W-1:0] div_q;
    acg_mode_t        mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= '0;
            mode_q <= '0;
        end else if (!enable) begin
            div_q  <= div_i;
            mode_q <= mode_i;
        end
    end

    assign div_o   = div_q;
    assign mode_o  = mode_q;
    assign legal_o = !((div_q == DIV_W'(1)) && mode_q.odd);

    // settings frozen while the stream runs
    assert_cfg_frozen_R11: assert property (@(posedge clk) disable iff (rst)
        (enable && $past(enable) && !$past(rst)) |-> ($stable(div_q) && $stable(mode_q)));

endmodule

// File: rtl/acg_prescaler.sv
`timescale 1ns/1ps
module acg_prescaler #(
    parameter int DIV_W = 8,
    localparam int CNT_W = DIV_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    input  logic             odd,
    output logic             base_o,
    output logic             tick_o,
    output logic             bypass_o
);

    logic [CNT_W-1:0] ratio;
    logic [CNT_W-1:0] p_q;
    logic [CNT_W-1:0] p_nxt;
    logic             base_q;
    logic             bypass;
    logic             tick;

    always_comb begin
        bypass = (div == '0);
        ratio  = bypass ? CNT_W'(1) : ({div, 1'b0} + CNT_W'(odd));
        tick   = run && (p_q == ratio - CNT_W'(1));
        p_nxt  = tick ? '0 : p_q + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst || !go) begin
            p_q    <= '0;
            base_q <= 1'b0;
        end else if (run) begin
            p_q    <= p_nxt;
            base_q <= !bypass && (p_nxt >= {1'b0, div});
        end
    end

    assign base_o   = base_q;
    assign tick_o   = tick;
    assign bypass_o = bypass;

    assert_phase_range_R1: assert property (@(posedge clk) disable iff (rst)
        run |-> (p_q < ratio));

    assert_rise_after_low_R2: assert property (@(posedge clk) disable iff (rst)
        (run && !bypass && $rose(base_q)) |-> (p_q == {1'b0, div}));

    assert_fall_at_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && $fell(base_q)) |-> (p_q == '0));

endmodule

// File: rtl/acg_framer.sv
`timescale 1ns/1ps
module acg_framer
    import acg_pkg::*;
#(
    localparam int N_MAX = MCLK_FS_STD / (2 * CH_SHORT_BITS),
    localparam int M_W   = $clog2(N_MAX),
    localparam int B_W   = $clog2(2 * CH_LONG_BITS)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  logic       run,
    input  logic       tick,
    input  logic       mclk_en,
    input  logic       chan_wide,
    input  frame_std_e std,
    output logic       sck_o,
    output logic       ws_o
);

    logic [M_W-1:0] m_q;
    logic [M_W-1:0] m_nxt;
    logic [B_W-1:0] bit_q;
    logic [B_W-1:0] bit_nxt;
    logic           sck_q;
    logic           ws_q;
    logic           m_last;
    logic           sck_start;
    logic           sck_nxt;
    logic           ws_nxt;
    logic           ws_first;
    int unsigned    n_per_bit;
    int unsigned    ch;
    int unsigned    frame_bits;

    always_comb begin
        n_per_bit  = mclk_per_bit(std, chan_wide);
        ch         = chan_bits(chan_wide);
        frame_bits = 2 * ch;
        m_last     = (32'(m_q) == n_per_bit - 1);
        m_nxt      = m_last ? '0 : m_q + M_W'(1);
        sck_nxt    = (32'(m_nxt) >= n_per_bit / 2);
        sck_start  = tick && (!mclk_en || m_last);
        bit_nxt    = (32'(bit_q) == frame_bits - 1) ? '0 : bit_q + B_W'(1);
        ws_nxt     = ws_for_bit(std, 32'(bit_nxt), ch);
        ws_first   = ws_for_bit(std, 0, ch);
    end

    always_ff @(posedge clk) begin
        if (rst || !go) begin
            m_q   <= '0;
            sck_q <= 1'b0;
            bit_q <= '0;
            ws_q  <= 1'b0;
        end else if (!run) begin
            ws_q  <= ws_first;
        end else begin
            if (tick && mclk_en) begin
                m_q   <= m_nxt;
                sck_q <= sck_nxt;
            end
            if (sck_start) begin
                bit_q <= bit_nxt;
                ws_q  <= ws_nxt;
            end
        end
    end

    assign sck_o = sck_q;
    assign ws_o  = ws_q;

    assert_bit_range_R7: assert property (@(posedge clk) disable iff (rst)
        run |-> (32'(bit_q) < frame_bits));

    assert_ws_on_bit_edge_R7: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && $past(go) && !$stable(ws_q)) |-> $past(sck_start));

    assert_sck_ratio_range_R5: assert property (@(posedge clk) disable iff (rst)
        (run && mclk_en) |-> (32'(m_q) < n_per_bit));

endmodule

// File: rtl/acg_top.sv
`timescale 1ns/1ps
module acg_top
    import acg_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [DIV_W-1:0] div_ratio,
    input  logic             div_odd,
    input  logic             mclk_out_en,
    input  logic             chan_wide,
    input  logic [1:0]       frame_std,
    input  logic             sck_invert,
    input  logic             ws_invert,
    output logic             mclk,
    output logic             sck,
    output logic             ws,
    output logic             cfg_err
);

    acg_mode_t        mode_in;
    acg_mode_t        mode;
    logic [DIV_W-1:0] div_sh;
    logic             legal;
    logic             go;
    logic             run_q;
    logic             base_q;
    logic             tick;
    logic             bypass;
    logic             base_clk;
    logic             sck_div;
    logic             ws_q;

    always_comb begin
        mode_in.odd       = div_odd;
        mode_in.mclk_en   = mclk_out_en;
        mode_in.chan_wide = chan_wide;
        mode_in.std       = frame_std_e'(frame_std);
        mode_in.sck_inv   = sck_invert;
        mode_in.ws_inv    = ws_invert;
    end

    acg_cfg_hold #(.DIV_W(DIV_W)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .enable  (enable),
        .div_i   (div_ratio),
        .mode_i  (mode_in),
        .div_o   (div_sh),
        .mode_o  (mode),
        .legal_o (legal)
    );

    assign go = enable && legal;

    always_ff @(posedge clk) begin
        if (rst) run_q <= 1'b0;
        else     run_q <= go;
    end

    acg_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .go       (go),
        .run      (run_q),
        .div      (div_sh),
        .odd      (mode.odd),
        .base_o   (base_q),
        .tick_o   (tick),
        .bypass_o (bypass)
    );

    acg_framer u_frm (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .run       (run_q),
        .tick      (tick),
        .mclk_en   (mode.mclk_en),
        .chan_wide (mode.chan_wide),
        .std       (mode.std),
        .sck_o     (sck_div),
        .ws_o      (ws_q)
    );

    // bypass: inverted kernel clock so that its falling edge meets the register updates
    assign base_clk = bypass ? (run_q && !clk) : base_q;
    assign mclk     = mode.mclk_en && base_clk;
    assign sck      = (mode.mclk_en ? sck_div : base_clk) ^ mode.sck_inv;
    assign ws       = ws_q ^ mode.ws_inv;
    assign cfg_err  = !legal;

    assert_err_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> (!mclk && (sck == mode.sck_inv) && (ws == mode.ws_inv)));

    assert_stopped_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !run_q |-> (!mclk && (sck == mode.sck_inv) && (ws == mode.ws_inv)));

    assert_mclk_off_R6: assert property (@(posedge clk) disable iff (rst)
        !mode.mclk_en |-> !mclk);

    assert_no_run_illegal_R4: assert property (@(posedge clk) disable iff (rst)
        (run_q && $past(run_q)) |-> legal);

endmodule

// File: tb/sim_acg_top.sv
`timescale 1ns/1ps
module sim_acg_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       enable;
    logic [7:0] div_ratio;
    logic       div_odd;
    logic       mclk_out_en;
    logic       chan_wide;
    logic [1:0] frame_std;
    logic       sck_invert;
    logic       ws_invert;
    logic       mclk;
    logic       sck;
    logic       ws;
    logic       cfg_err;

    int errs = 0;
    int checks = 0;
    int md, mo, moe, mch, mstd, mck, mwv;

    always #2.5 clk = ~clk;

    acg_top u0 (
        .clk (clk), .rst (rst), .enable (enable),
        .div_ratio (div_ratio), .div_odd (div_odd), .mclk_out_en (mclk_out_en),
        .chan_wide (chan_wide), .frame_std (frame_std),
        .sck_invert (sck_invert), .ws_invert (ws_invert),
        .mclk (mclk), .sck (sck), .ws (ws), .cfg_err (cfg_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // waveform model built from the requirements
    function automatic void model(input int t, input bit ph2,
                                  output bit em, output bit es, output bit ew);
        int r, n, chb, fb, k, b;
        bit base, sv, wv;
        r   = (md == 0) ? 1 : 2 * md + mo;
        chb = mch ? 32 : 16;
        fb  = 2 * chb;
        n   = ((mstd == 3) ? 128 : 256) / fb;
        if (md == 0) base = ph2;
        else         base = ((t % r) >= md);
        k = t / r;
        if (moe != 0) begin
            sv = ((k % n) >= n / 2);
            b  = (k / n) % fb;
        end else begin
            sv = base;
            b  = k % fb;
        end
        case (mstd)
            0:       wv = (b >= chb);
            1, 2:    wv = (b < chb);
            default: wv = (b == 0);
        endcase
        em = (moe != 0) && base;
        es = sv ^ mck[0];
        ew = wv ^ mwv[0];
    endfunction

    task automatic apply_cfg(input int d, input int o, input int oe, input int ch,
                             input int st, input int ck, input int wv);
        @(negedge clk);
        enable = 1'b0;
        md = d; mo = o; moe = oe; mch = ch; mstd = st; mck = ck; mwv = wv;
        div_ratio = 8'(d); div_odd = o[0]; mclk_out_en = oe[0]; chan_wide = ch[0];
        frame_std = 2'(st); sck_invert = ck[0]; ws_invert = wv[0];
    endtask

    task automatic run_window(input string req, input int cycles, input bit mid_change);
        int  bad [3];
        int  fa [3];
        int  fe [3];
        bit  em, es, ew;
        bit  act [3];
        bit  exv [3];
        string nm [3];
        nm[0] = "mclk"; nm[1] = "sck"; nm[2] = "ws";
        for (int s = 0; s < 3; s++) begin bad[s] = 0; fa[s] = 0; fe[s] = 0; end
        @(negedge clk);
        enable = 1'b1;
        for (int t = 0; t < cycles; t++) begin
            for (int ph = 0; ph < 2; ph++) begin
                if (ph == 0) begin
                    @(posedge clk); #1;
                end else begin
                    if (md != 0) break;
                    @(negedge clk); #1;
                end
                model(t, ph[0], em, es, ew);
                act[0] = mclk; act[1] = sck; act[2] = ws;
                exv[0] = em;   exv[1] = es;  exv[2] = ew;
                for (int s = 0; s < 3; s++) begin
                    if (act[s] != exv[s]) begin
                        if (bad[s] == 0) begin fa[s] = int'(act[s]); fe[s] = int'(exv[s]); end
                        bad[s]++;
                    end
                end
            end
            if (mid_change && t == cycles / 2) begin
                div_ratio = div_ratio ^ 8'h5A; div_odd = ~div_odd;
                mclk_out_en = ~mclk_out_en; chan_wide = ~chan_wide;
                frame_std = ~frame_std; sck_invert = ~sck_invert; ws_invert = ~ws_invert;
            end
        end
        for (int s = 0; s < 3; s++)
            chk(bad[s] == 0, req, $sformatf("%s waveform (first mismatch of %0d)", nm[s], bad[s]),
                fa[s], fe[s]);
    endtask

    task automatic stop_idle(input string req);
        @(negedge clk);
        enable = 1'b0;
        @(posedge clk); #1;
        chk(mclk == 1'b0, req, "stopped mclk", int'(mclk), 0);
        chk(sck == sck_invert, req, "stopped sck", int'(sck), int'(sck_invert));
        chk(ws == ws_invert, req, "stopped ws", int'(ws), int'(ws_invert));
    endtask

    task automatic t_reset();
        rst = 1'b1; enable = 1'b0; div_ratio = 8'd0; div_odd = 1'b0; mclk_out_en = 1'b0;
        chan_wide = 1'b0; frame_std = 2'd0; sck_invert = 1'b0; ws_invert = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk(mclk == 1'b0, "R10", "reset mclk", int'(mclk), 0);
        chk(sck == 1'b0, "R10", "reset sck", int'(sck), 0);
        chk(ws == 1'b0, "R10", "reset ws", int'(ws), 0);
        chk(cfg_err == 1'b0, "R4", "reset cfg_err", int'(cfg_err), 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_even_i2s();      // R1 R2 R5 R8 R12: ratio 4, N=8
        apply_cfg(2, 0, 1, 0, 0, 0, 0);
        run_window("R1/R2/R5/R8/R12", 1200, 1'b0);
        stop_idle("R10");
    endtask

    task automatic t_odd_msb_nomclk(); // R2 R6 R7: ratio 5, 32-bit channels
        apply_cfg(2, 1, 0, 1, 1, 0, 0);
        run_window("R2/R6/R7/R8", 700, 1'b0);
        stop_idle("R10");
    endtask

    task automatic t_pcm_short();     // R5 R8: 128 fs, 16-bit, N=4
        apply_cfg(1, 0, 1, 0, 3, 0, 0);
        run_window("R5/R8", 600, 1'b0);
        stop_idle("R10");
    endtask

    task automatic t_pcm_wide_inv();  // R5 R9: 128 fs, 32-bit, N=2, both inverted
        apply_cfg(3, 1, 1, 1, 3, 1, 1);
        run_window("R5/R9", 1000, 1'b0);
        stop_idle("R9/R10");
    endtask

    task automatic t_lsb_wide();      // R5 R8 R9: N=4, sck inverted
        apply_cfg(1, 0, 1, 1, 2, 1, 0);
        run_window("R5/R8/R9", 600, 1'b0);
        stop_idle("R10");
    endtask

    task automatic t_bypass();        // R3
        apply_cfg(0, 0, 0, 0, 0, 0, 0);
        run_window("R3/R6", 100, 1'b0);
        stop_idle("R10");
        apply_cfg(0, 1, 1, 0, 1, 0, 1);
        run_window("R3/R5", 300, 1'b0);
        stop_idle("R10");
    endtask

    task automatic t_largest();       // R1 R2: ratio 511
        apply_cfg(255, 1, 0, 0, 0, 0, 0);
        run_window("R1/R2", 2000, 1'b0);
        stop_idle("R10");
    endtask

    task automatic t_frozen();        // R11
        apply_cfg(4, 1, 0, 0, 0, 0, 0);
        run_window("R11", 400, 1'b1);
        stop_idle("R11/R10");
        apply_cfg(1, 0, 1, 0, 3, 0, 1);
        run_window("R11/R12", 300, 1'b0);
        stop_idle("R10");
    endtask

    task automatic t_illegal();       // R4
        int bad;
        apply_cfg(1, 1, 1, 0, 0, 1, 0);
        @(posedge clk); #1;
        chk(cfg_err == 1'b1, "R4", "cfg_err after illegal setting", int'(cfg_err), 1);
        @(negedge clk);
        enable = 1'b1;
        bad = 0;
        repeat (60) begin
            @(posedge clk); #1;
            if (mclk != 1'b0 || sck != 1'b1 || ws != 1'b0) bad++;
        end
        chk(bad == 0, "R4", "cycles with clock activity while illegal", bad, 0);
        chk(cfg_err == 1'b1, "R4", "cfg_err held while enabled", int'(cfg_err), 1);
        @(negedge clk);
        enable = 1'b0; div_odd = 1'b0;
        @(posedge clk); #1;
        chk(cfg_err == 1'b0, "R4", "cfg_err after legal setting", int'(cfg_err), 0);
    endtask

    task automatic t_idle_pol();      // R9 R10
        apply_cfg(2, 0, 1, 0, 0, 1, 1);
        @(posedge clk); #1;
        chk(sck == 1'b1, "R9", "idle sck inverted", int'(sck), 1);
        chk(ws == 1'b1, "R9", "idle ws inverted", int'(ws), 1);
        chk(mclk == 1'b0, "R10", "idle mclk", int'(mclk), 0);
    endtask

    initial begin
        t_reset();
        t_even_i2s();
        t_odd_msb_nomclk();
        t_pcm_short();
        t_pcm_wide_inv();
        t_lsb_wide();
        t_bypass();
        t_largest();
        t_frozen();
        t_illegal();
        t_idle_pol();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule